// File: doc/BRIEF.md
# Bus Adapter Control Register File

This block holds the control state of an adapter that connects an 18-bit peripheral bus to a memory made of 36-bit words. Register accesses arrive on a request channel with an 18-bit address, an 18-bit write value and a byte qualifier. Accesses that land in a fixed 128-address window starting at octal 763000 reach either one of 64 page-map entries or a status register. Every other access in the window, and every access outside it, is answered with an error. Forwarding to attached peripherals is not part of this block, so such accesses are reported as not found.

Map writes repack the bus value into the stored map format: a page number plus four flag bits. The status register combines several kinds of bits. Some take the written value. Some error bits stick until they are cleared by writing 1 or by an init command. An init command also emits a one-cycle reset pulse to the devices on the adapter. Two interrupt-pending inputs are merged into the value returned on a status read. A parity-error input sets a sticky bit.

Requests use valid/ready. A request is accepted on a clock edge where both are high. Exactly one response follows in the next cycle on a valid/ready response channel. While a response waits with `rsp_ready` low, `req_ready` stays low and the response holds its value. Control pins (`dev_reset`, interrupt flags, parity event) have no handshake.

Top module: `bar_regfile`

## Requirements
- R1: A request accepted at an edge produces `rsp_valid` high after that edge. `req_ready` is high when no response is pending or the pending one is being taken. A stalled response keeps `rsp_err` and `rsp_rdata` unchanged. Write responses carry zero data.
- R2: A word write to a map address stores write bits [10:0] at entry bits [19:9] and write bits [17:14] at entry bits [30:27]. All other entry bits are zero. A read of that address returns the 36-bit entry.
- R3: Address bits [5:0] in 763000–763077 select one of 64 entries. A write changes only the selected entry.
- R4: A status read (octal 763100) returns the stored status with bit 10 equal to `irq_lo_pend` and bit 11 equal to `irq_hi_pend`, both sampled at the accepting edge.
- R5: A status write replaces bits [5:0] and bit 7 with the written value. Bit 6 is never stored and reads 0. Writing 1 to any of bits 14..11 clears the stored bit; only bit 14 is stored there.
- R6: A status write with bit 6 set first clears all of the status and then applies the R5 low-field load. `dev_reset` is high for exactly the cycle after that edge.
- R7: An access to any window address other than the map, status and 763101, or to any address outside the window, gets `rsp_err`=1 and zero data. It also sets status bits 17 (timeout) and 14 (no device). Bits 17..15 are cleared only by init or reset.
- R8: Address 763101 reads as zero with no error. A write to it changes no state.
- R9: On a byte write, only write bits [7:0] are used. They go to bits [15:8] for an odd address and to bits [7:0] for an even address; all other bits are zero.
- R10: A one-cycle `parity_evt` pulse sets status bit 15. When it coincides with a status write, it takes effect after that write.
- R11: Synchronous reset clears all map entries, the status register and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | Byte-sized access |
| req_addr | input | 18 | Bus address |
| req_wdata | input | 18 | Write value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Access not found / not allowed |
| rsp_rdata | output | 36 | Read value |
| dev_reset | output | 1 | One-cycle device reset pulse |
| irq_lo_pend | input | 1 | Low-priority interrupt pending |
| irq_hi_pend | input | 1 | High-priority interrupt pending |
| parity_evt | input | 1 | Parity error event |

## Verification
Map packing is tried with write values that have all flag and page bits set, with a single bit in each field, and with bits 13..11 set. These show whether the field positions are right and whether the gap bits are dropped. Status writes are tried with plain low-field loads, with write-one-to-clear on the no-device bit, with an attempt to clear the sticky timeout, and with an init command. Together these separate the four bit classes. Interrupt inputs are tried one at a time to tell bit 10 from bit 11. Byte writes at odd and even addresses, with garbage above bit 7, show the lane placement. A stalled response with a competing request confirms that nothing is accepted under back-pressure.

// File: rtl/bar_pkg.sv
package bar_pkg;
  typedef enum logic [1:0] {SEL_MAP, SEL_STAT, SEL_ZERO, SEL_NONE} sel_e;

  localparam int ST_W     = 18;
  localparam int ST_INIT  = 6;
  localparam int ST_IRQLO = 10;
  localparam int ST_IRQHI = 11;
  localparam int ST_NED   = 14;
  localparam int ST_PAR   = 15;
  localparam int ST_TIM   = 17;
  localparam int W1C_LO   = 11;
  localparam int W1C_HI   = 14;
  localparam logic [ST_W-1:0] ST_KEEP = 18'h3C0BF;

  localparam int PG_W     = 11;
  localparam int PG_POS   = 9;
  localparam int FL_SRC   = 14;
  localparam int FL_W     = 4;
  localparam int FL_POS   = 27;

  function automatic logic [17:0] lane_place(input logic byt, input logic odd,
                                             input logic [17:0] wd);
    logic [17:0] r;
    if (!byt)     r = wd;
    else if (odd) r = {2'b00, wd[7:0], 8'h00};
    else          r = {10'h000, wd[7:0]};
    return r;
  endfunction
endpackage

// File: rtl/bar_decode.sv
module bar_decode
  import bar_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int IDX_W  = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 18'o763000
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int WIN_LSB = IDX_W + 1;

  logic in_win;
  assign in_win = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign idx    = addr[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (in_win) begin
      if (!addr[IDX_W])                 sel = SEL_MAP;
      else if (idx == '0)               sel = SEL_STAT;
      else if (idx == IDX_W'(1))        sel = SEL_ZERO;
      else                              sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/bar_map_store.sv
module bar_map_store
  import bar_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 18,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wd,
  output logic [WORD_W-1:0] rd
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] packed_wd;
  logic [WORD_W-1:0] ent [DEPTH];

  always_comb begin
    packed_wd = '0;
    packed_wd[PG_POS +: PG_W] = wd[PG_W-1:0];
    packed_wd[FL_POS +: FL_W] = wd[FL_SRC +: FL_W];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                          ent[i] <= '0;
      else if (we && idx == IDX_W'(i))  ent[i] <= packed_wd;
    end
  end

  assign rd = ent[idx];
endmodule

// File: rtl/bar_status_reg.sv
module bar_status_reg
  import bar_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            err,
  input  logic            parity_evt,
  input  logic [ST_W-1:0] wd,
  output logic [ST_W-1:0] status_q,
  output logic            dev_reset
);
  logic [ST_W-1:0] nxt;
  logic            init_now;

  always_comb begin
    nxt      = status_q;
    init_now = 1'b0;
    if (wr) begin
      nxt[W1C_HI:W1C_LO] = nxt[W1C_HI:W1C_LO] & ~wd[W1C_HI:W1C_LO];
      if (wd[ST_INIT]) begin
        nxt      = '0;
        init_now = 1'b1;
      end
      nxt[5:0] = wd[5:0];
      nxt[7]   = wd[7];
    end
    if (err) begin
      nxt[ST_TIM] = 1'b1;
      nxt[ST_NED] = 1'b1;
    end
    if (parity_evt) nxt[ST_PAR] = 1'b1;
    nxt = nxt & ST_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      dev_reset <= 1'b0;
    end else begin
      status_q  <= nxt;
      dev_reset <= init_now;
    end
  end
endmodule

// File: rtl/bar_regfile.sv
module bar_regfile
  import bar_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 18,
  parameter int WORD_W = 36,
  parameter int IDX_W  = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 18'o763000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              dev_reset,
  input  logic              irq_lo_pend,
  input  logic              irq_hi_pend,
  input  logic              parity_evt
);
  sel_e              sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wd;
  logic [WORD_W-1:0] map_rd;
  logic [ST_W-1:0]   status_q;
  logic [ST_W-1:0]   st_view;
  logic [WORD_W-1:0] rd_val;
  logic              acc;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wd        = lane_place(req_byte, req_addr[0], req_wdata);

  bar_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr(req_addr), .sel(sel), .idx(idx)
  );

  bar_map_store #(.IDX_W(IDX_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_map (
    .clk(clk), .rst(rst),
    .we(acc && req_write && sel == SEL_MAP),
    .idx(idx), .wd(wd), .rd(map_rd)
  );

  bar_status_reg u_st (
    .clk(clk), .rst(rst),
    .wr(acc && req_write && sel == SEL_STAT),
    .err(acc && sel == SEL_NONE),
    .parity_evt(parity_evt),
    .wd(wd[ST_W-1:0]),
    .status_q(status_q),
    .dev_reset(dev_reset)
  );

  always_comb begin
    st_view           = status_q;
    st_view[ST_IRQLO] = irq_lo_pend;
    st_view[ST_IRQHI] = irq_hi_pend;
    case (sel)
      SEL_MAP:  rd_val = map_rd;
      SEL_STAT: rd_val = WORD_W'(st_view);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_err   <= (sel == SEL_NONE);
      rsp_rdata <= req_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bar_checker.sv
module bar_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_err,
  input logic [35:0] rsp_rdata,
  input logic        dev_reset,
  input logic        parity_evt,
  input logic [17:0] status_q
);
  a_r1_accept_gives_rsp: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  a_r1_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dev_reset |=> !dev_reset);

  a_r6_init_cleared: assert property (@(posedge clk) disable iff (rst)
    dev_reset |-> (status_q[17:16] == 2'b00 && !status_q[14]));

  a_r7_err_no_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 36'h0));

  a_r10_parity_sets: assert property (@(posedge clk) disable iff (rst)
    parity_evt |=> status_q[15]);

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!rsp_valid && status_q == 18'h0 && !dev_reset));
endmodule

bind bar_regfile bar_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .dev_reset(dev_reset), .parity_evt(parity_evt),
  .status_q(status_q)
);

// File: tb/tb_bar_regfile.sv
module tb_bar_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [17:0] req_addr = '0, req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        irq_lo_pend = 1'b0, irq_hi_pend = 1'b0, parity_evt = 1'b0;
  logic        req_ready, rsp_valid, rsp_err, dev_reset;
  logic [35:0] rsp_rdata;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bar_regfile dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .dev_reset(dev_reset),
    .irq_lo_pend(irq_lo_pend), .irq_hi_pend(irq_hi_pend), .parity_evt(parity_evt)
  );

  typedef struct packed {
    logic        wr;
    logic        byt;
    logic [17:0] addr;
    logic [17:0] wd;
    logic        lo;
    logic        hi;
    logic        err;
    logic [35:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{0, 0, 18'o763100, 18'h0,     0, 0, 0, 36'h0,         4'd11}, // R11 status after reset
    '{1, 0, 18'o763005, 18'h3C7FF, 0, 0, 0, 36'h0,         4'd1},  // R1 write rsp zero
    '{0, 0, 18'o763005, 18'h0,     0, 0, 0, 36'h0780FFE00, 4'd2},  // R2 all fields
    '{1, 0, 18'o763077, 18'h04001, 0, 0, 0, 36'h0,         4'd2},
    '{0, 0, 18'o763077, 18'h0,     0, 0, 0, 36'h008000200, 4'd2},  // R2 single bits
    '{0, 0, 18'o763005, 18'h0,     0, 0, 0, 36'h0780FFE00, 4'd3},  // R3 untouched
    '{0, 0, 18'o763000, 18'h0,     0, 0, 0, 36'h0,         4'd3},  // R3 other entry
    '{1, 0, 18'o763100, 18'o277,   0, 0, 0, 36'h0,         4'd5},
    '{0, 0, 18'o763100, 18'h0,     1, 0, 0, 36'h4BF,       4'd4},  // R4 low pend bit 10
    '{0, 0, 18'o763100, 18'h0,     0, 1, 0, 36'h8BF,       4'd4},  // R4 high pend bit 11
    '{1, 0, 18'o763100, 18'h00045, 0, 0, 0, 36'h0,         4'd6},  // R6 init
    '{0, 0, 18'o763100, 18'h0,     0, 0, 0, 36'h005,       4'd6},
    '{0, 0, 18'o763101, 18'h0,     0, 0, 0, 36'h0,         4'd8},  // R8 zero reg
    '{1, 0, 18'o763101, 18'h3FFFF, 0, 0, 0, 36'h0,         4'd8},
    '{0, 0, 18'o763100, 18'h0,     0, 0, 0, 36'h005,       4'd8},  // R8 no effect
    '{0, 0, 18'o763102, 18'h0,     0, 0, 1, 36'h0,         4'd7},  // R7 hole in window
    '{0, 0, 18'o763100, 18'h0,     0, 0, 0, 36'h24005,     4'd7},
    '{1, 0, 18'o763100, 18'h04005, 0, 0, 0, 36'h0,         4'd5},  // R5 w1c bit 14
    '{0, 0, 18'o763100, 18'h0,     0, 0, 0, 36'h20005,     4'd5},
    '{1, 0, 18'o100000, 18'h1,     0, 0, 1, 36'h0,         4'd7},  // R7 outside window
    '{1, 0, 18'o763100, 18'h3C005, 0, 0, 0, 36'h0,         4'd7},
    '{0, 0, 18'o763100, 18'h0,     0, 0, 0, 36'h20005,     4'd7},  // R7 timeout sticky
    '{1, 1, 18'o763100, 18'h00103, 0, 0, 0, 36'h0,         4'd9},  // R9 even byte
    '{0, 0, 18'o763100, 18'h0,     0, 0, 0, 36'h20003,     4'd9},
    '{1, 1, 18'o763003, 18'h3FF12, 0, 0, 0, 36'h0,         4'd9},  // R9 odd byte
    '{0, 0, 18'o763003, 18'h0,     0, 0, 0, 36'h000040000, 4'd9},
    '{1, 1, 18'o763002, 18'h0FF,   0, 0, 0, 36'h0,         4'd9}
  };

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic byt, input logic [17:0] a,
                        input logic [17:0] d, input logic lo, input logic hi,
                        output logic e, output logic [35:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = byt; req_addr = a; req_wdata = d;
    irq_lo_pend = lo; irq_hi_pend = hi;
    @(negedge clk);
    req_valid = 1'b0; irq_lo_pend = 1'b0; irq_hi_pend = 1'b0;
    e = rsp_err; r = rsp_rdata;
    compared++;
    if (rsp_valid !== 1'b1) begin
      mismatched++;
      $display("FAIL R1: rsp_valid actual %b expected 1", rsp_valid);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic        e;
    logic [35:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 rsp_valid after reset", {35'h0, rsp_valid}, 36'h0);
    check("R1 req_ready idle", {35'h0, req_ready}, 36'h1);
    check("R11 dev_reset after reset", {35'h0, dev_reset}, 36'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].byt, VEC[i].addr, VEC[i].wd, VEC[i].lo, VEC[i].hi, e, r);
      check($sformatf("R%0d vec %0d err", VEC[i].req, i), {35'h0, e}, {35'h0, VEC[i].err});
      check($sformatf("R%0d vec %0d data", VEC[i].req, i), r, VEC[i].exp);
    end
    access(0, 0, 18'o763002, 0, 0, 0, e, r);
    check("R9 even byte map", r, 36'h00001FE00);

    // R6: init pulse timing; plain write gives no pulse
    @(negedge clk);
    req_valid = 1; req_write = 1; req_byte = 0; req_addr = 18'o763100; req_wdata = 18'h41;
    @(negedge clk);
    req_valid = 0;
    check("R6 dev_reset high", {35'h0, dev_reset}, 36'h1);
    @(negedge clk);
    check("R6 dev_reset one cycle", {35'h0, dev_reset}, 36'h0);
    access(1, 0, 18'o763100, 18'h02, 0, 0, e, r);
    check("R6 no pulse without init", {35'h0, dev_reset}, 36'h0);
    access(0, 0, 18'o763100, 0, 0, 0, e, r);
    check("R5 status after plain write", r, 36'h002);

    // R10: parity pulse
    @(negedge clk); parity_evt = 1;
    @(negedge clk); parity_evt = 0;
    access(0, 0, 18'o763100, 0, 0, 0, e, r);
    check("R10 parity bit 15", r, 36'h08002);

    // R1: back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_byte = 0; req_addr = 18'o763005;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 18'o763100; req_wdata = 18'h3F;
    check("R1 stalled rsp data", rsp_rdata, 36'h0780FFE00);
    check("R1 ready low when stalled", {35'h0, req_ready}, 36'h0);
    repeat (3) @(negedge clk);
    check("R1 stalled rsp held", rsp_rdata, 36'h0780FFE00);
    check("R1 still valid", {35'h0, rsp_valid}, 36'h1);
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    check("R1 rsp consumed", {35'h0, rsp_valid}, 36'h0);
    access(0, 0, 18'o763100, 0, 0, 0, e, r);
    check("R1 blocked write not taken", r, 36'h08002);

    // R11: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    access(0, 0, 18'o763005, 0, 0, 0, e, r);
    check("R11 map cleared", r, 36'h0);
    access(0, 0, 18'o763100, 0, 0, 0, e, r);
    check("R11 status cleared", r, 36'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule